// File: doc/BRIEF.md
# Instruction condition code evaluator

This purely combinational unit decides whether a conditionally executed instruction may proceed. It reads four status flags (negative, zero, carry, overflow) from a status word and compares them with a 4-bit condition selector. A single pass bit comes out in the same cycle, for issue or retire logic to use.

The selector comes from one of two instruction formats. A full-width instruction holds it in its top nibble. A compact branch instruction holds it in the nibble just above its low byte. A plain mode pin picks the format. No data stream passes through the block, so it has no valid/ready handshake. All pins are plain level signals, and the output depends only on the present inputs.

Top module: `cond_gate`

## Requirements
- R1: When `use_narrow` is 0, the selector is `wide_insn[31:28]`.
- R2: When `use_narrow` is 1, the selector is `narrow_insn[11:8]`.
- R3: The flags are read from `status_word`: N from bit 31, Z from bit 30, C from bit 29 and V from bit 28. Bits 27:0 of `status_word` have no effect on `cond_pass`.
- R4: Selector values 0 to 7 test a single flag:
  - 0 passes when Z=1, and 1 passes when Z=0.
  - 2 passes when C=1, and 3 passes when C=0.
  - 4 passes when N=1, and 5 passes when N=0.
  - 6 passes when V=1, and 7 passes when V=0.
- R5: Selector 8 passes when C=1 and Z=0. Selector 9 passes when C=0 or Z=1.
- R6: Selector 10 passes when N equals V. Selector 11 passes when N differs from V.
- R7: Selector 12 passes when Z=0 and N equals V. Selector 13 passes when Z=1 or N differs from V, which is exactly the complement of selector 12.
- R8: Selector values 14 and 15 always pass, whatever the flags are.
- R9: The instruction word that is not selected has no effect on `cond_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| status_word | input | 32 | Status word carrying N, Z, C and V in bits 31 to 28 |
| wide_insn | input | 32 | Full-width instruction; selector in bits 31:28 |
| narrow_insn | input | 16 | Compact branch instruction; selector in bits 11:8 |
| use_narrow | input | 1 | Format select: 1 takes the selector from `narrow_insn` |
| cond_pass | output | 1 | 1 when the instruction may proceed |

## Verification
The hardest case to reach from the ports is code 15 in the odd "complement" position. It must pass even though every other odd code inverts its even partner, so an error there shows only when all flag states are applied to selector 15 in both formats. The directed sweep applies every selector against all sixteen flag combinations in both modes. While it does so, it fills the unselected word and the low status bits with random values, so that any leak from them changes the result.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned COND_W = 4;

  typedef logic [COND_W-1:0] cond_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Even selector of each pair; the odd neighbour is its complement (except 15).
  typedef enum logic [COND_W-1:0] {
    SEL_ZERO    = 4'd0,
    SEL_CARRY   = 4'd2,
    SEL_NEG     = 4'd4,
    SEL_OVF     = 4'd6,
    SEL_UGT     = 4'd8,
    SEL_SGE     = 4'd10,
    SEL_SGT     = 4'd12,
    SEL_ANY     = 4'd14
  } pair_base_e;
endpackage

// File: rtl/cond_flag_tap.sv
module cond_flag_tap
  import cond_pkg::*;
#(
  parameter int unsigned STATUS_W = 32,
  parameter int unsigned N_POS    = 31,
  parameter int unsigned Z_POS    = 30,
  parameter int unsigned C_POS    = 29,
  parameter int unsigned V_POS    = 28
) (
  input  logic [STATUS_W-1:0] status_word,
  output flags_t              flags
);
  always_comb begin
    flags.n = status_word[N_POS];
    flags.z = status_word[Z_POS];
    flags.c = status_word[C_POS];
    flags.v = status_word[V_POS];
  end
endmodule

// File: rtl/cond_field_pick.sv
module cond_field_pick
  import cond_pkg::*;
#(
  parameter int unsigned WIDE_W     = 32,
  parameter int unsigned NARROW_W   = 16,
  parameter int unsigned WIDE_LSB   = 28,
  parameter int unsigned NARROW_LSB = 8
) (
  input  logic [WIDE_W-1:0]   wide_insn,
  input  logic [NARROW_W-1:0] narrow_insn,
  input  logic                use_narrow,
  output cond_t               sel
);
  localparam int unsigned WIDE_MSB   = WIDE_LSB + COND_W - 1;
  localparam int unsigned NARROW_MSB = NARROW_LSB + COND_W - 1;

  cond_t wide_sel;
  cond_t narrow_sel;

  assign wide_sel   = wide_insn[WIDE_MSB:WIDE_LSB];
  assign narrow_sel = narrow_insn[NARROW_MSB:NARROW_LSB];

  always_comb begin
    sel = use_narrow ? narrow_sel : wide_sel;
  end
endmodule

// File: rtl/cond_judge.sv
module cond_judge
  import cond_pkg::*;
(
  input  cond_t  sel,
  input  flags_t flags,
  output logic   pass
);
  localparam int unsigned PAIRS = 1 << (COND_W - 1);

  logic [PAIRS-1:0] even_term;
  logic             signs_match;
  logic [COND_W-2:0] pair_idx;
  logic             always_pair;

  assign signs_match = ~(flags.n ^ flags.v);
  assign pair_idx    = sel[COND_W-1:1];
  assign always_pair = (pair_idx == PAIRS[COND_W-2:0] - 1'b1);

  always_comb begin
    even_term    = '0;
    even_term[0] = flags.z;
    even_term[1] = flags.c;
    even_term[2] = flags.n;
    even_term[3] = flags.v;
    even_term[4] = flags.c & ~flags.z;
    even_term[5] = signs_match;
    even_term[6] = ~flags.z & signs_match;
    even_term[7] = 1'b1;
  end

  always_comb begin
    if (always_pair) pass = 1'b1;
    else             pass = even_term[pair_idx] ^ sel[0];
  end
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_pkg::*;
#(
  parameter int unsigned STATUS_W   = 32,
  parameter int unsigned WIDE_W     = 32,
  parameter int unsigned NARROW_W   = 16,
  parameter int unsigned WIDE_LSB   = 28,
  parameter int unsigned NARROW_LSB = 8,
  parameter int unsigned FLAG_TOP   = 31
) (
  input  logic [STATUS_W-1:0] status_word,
  input  logic [WIDE_W-1:0]   wide_insn,
  input  logic [NARROW_W-1:0] narrow_insn,
  input  logic                use_narrow,
  output logic                cond_pass
);
  flags_t flags;
  cond_t  sel;

  cond_flag_tap #(
    .STATUS_W(STATUS_W),
    .N_POS(FLAG_TOP),
    .Z_POS(FLAG_TOP - 1),
    .C_POS(FLAG_TOP - 2),
    .V_POS(FLAG_TOP - 3)
  ) u_tap (
    .status_word(status_word),
    .flags(flags)
  );

  cond_field_pick #(
    .WIDE_W(WIDE_W),
    .NARROW_W(NARROW_W),
    .WIDE_LSB(WIDE_LSB),
    .NARROW_LSB(NARROW_LSB)
  ) u_pick (
    .wide_insn(wide_insn),
    .narrow_insn(narrow_insn),
    .use_narrow(use_narrow),
    .sel(sel)
  );

  cond_judge u_judge (
    .sel(sel),
    .flags(flags),
    .pass(cond_pass)
  );
endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk (
  input logic [31:0] status_word,
  input logic [31:0] wide_insn,
  input logic [15:0] narrow_insn,
  input logic        use_narrow,
  input logic        cond_pass
);
  logic [3:0] s;
  logic n, z, c, v;
  assign s = use_narrow ? narrow_insn[11:8] : wide_insn[31:28];
  assign n = status_word[31];
  assign z = status_word[30];
  assign c = status_word[29];
  assign v = status_word[28];

  always_comb begin
    // R8
    always_pass_chk: assert (!(s >= 4'd14) || cond_pass);
    // R7
    sgt_pair_chk: assert (!(s == 4'd12 || s == 4'd13) ||
                          (cond_pass == ((s == 4'd12) ? (!z && (n == v)) : (z || (n != v)))));
    // R6
    sign_cmp_chk: assert (!(s == 4'd10 || s == 4'd11) ||
                          (cond_pass == ((s == 4'd10) ? (n == v) : (n != v))));
    // R5
    unsigned_cmp_chk: assert (!(s == 4'd8 || s == 4'd9) ||
                              (cond_pass == ((s == 4'd8) ? (c && !z) : (!c || z))));
    // R4
    zero_flag_chk: assert (!(s == 4'd0) || (cond_pass == z));
  end
endmodule

bind cond_gate cond_gate_chk u_chk (
  .status_word(status_word),
  .wide_insn(wide_insn),
  .narrow_insn(narrow_insn),
  .use_narrow(use_narrow),
  .cond_pass(cond_pass)
);

// File: tb/cond_gate_tb.sv
module cond_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] status_word = '0;
  logic [31:0] wide_insn = '0;
  logic [15:0] narrow_insn = '0;
  logic        use_narrow = 1'b0;
  logic        cond_pass;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_gate u_dut (
    .status_word(status_word),
    .wide_insn(wide_insn),
    .narrow_insn(narrow_insn),
    .use_narrow(use_narrow),
    .cond_pass(cond_pass)
  );

  function automatic bit ref_pass(input logic [3:0] s, input logic [3:0] nzcv);
    bit n, z, c, v;
    n = nzcv[3]; z = nzcv[2]; c = nzcv[1]; v = nzcv[0];
    case (s)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    if (s <= 4'd7) return "R4";
    if (s <= 4'd9) return "R5";
    if (s <= 4'd11) return "R6";
    if (s <= 4'd13) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input bit exp);
    @(posedge clk);
    #1;
    checks++;
    if (cond_pass !== exp) begin
      fails++;
      $display("FAIL %s: cond_pass=%0b expected=%0b sel_mode=%0b status=%h wide=%h narrow=%h",
               req, cond_pass, exp, use_narrow, status_word, wide_insn, narrow_insn);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic [3:0] nzcv, input bit narrow);
    @(negedge clk);
    use_narrow  = narrow;
    status_word = {nzcv, 28'($urandom)};
    if (narrow) begin
      narrow_insn = {4'($urandom), s, 8'($urandom)};
      wide_insn   = $urandom;
    end else begin
      wide_insn   = {s, 28'($urandom)};
      narrow_insn = 16'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    // reset state: all-zero inputs, selector 0 with Z clear -> no pass (R1, R4)
    check("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // exhaustive selector x flags in both formats (R1, R2, R3, R4..R8)
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int f = 0; f < 16; f++) begin
          apply(4'(s), 4'(f), m[0]);
          check(m == 0 ? req_of(4'(s)) : "R2", ref_pass(4'(s), 4'(f)));
        end

    // R9: unselected word holds a contradicting selector; result unchanged
    @(negedge clk);
    use_narrow = 1'b0; status_word = 32'h0000_0000;
    wide_insn = 32'h0000_0000; narrow_insn = 16'h0E00;
    check("R9", 1'b0);
    @(negedge clk);
    use_narrow = 1'b1; narrow_insn = 16'h0100; wide_insn = 32'hE000_0000;
    status_word = 32'h4000_0000;
    check("R9", 1'b0);

    // R3: low status bits all set must not fake a flag
    @(negedge clk);
    use_narrow = 1'b0; status_word = 32'h0FFF_FFFF; wide_insn = 32'h2000_0000;
    check("R3", 1'b0);
    // R7 complement corner: Z set with N==V
    @(negedge clk);
    status_word = 32'hD000_0000; wide_insn = 32'hD000_0000;
    check("R7", 1'b1);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] rs, rf;
      bit rm;
      rs = 4'($urandom); rf = 4'($urandom); rm = 1'($urandom);
      apply(rs, rf, rm);
      check(rm ? "R2" : "R1", ref_pass(rs, rf));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule